// File: doc/BRIEF.md
# Three-Wire-Plus-Select Serial EEPROM Slave Model

This block models a small serial EEPROM. The array holds 64 words of 16 bits. It sits behind a four-wire slave interface: a chip select, a serial clock, a serial data input and a serial data output. The host raises chip select and clocks in a frame on rising edges of the serial clock. The frame is a start bit, a two-bit command code and a six-bit word address, with sixteen data bits after them for the two write-type commands. The block then reads, writes or erases the addressed word, erases or fills the whole array, or sets or clears a write-enable latch. That latch gates every programming command.

All four command codes except the read, write and single-word erase codes share the value 00. For these, the two upper address bits choose among write-enable, write-disable, erase-all and write-all. A read returns a zero bit first, then the word MSB first, one bit per rising serial-clock edge. Programming completes in a single system clock, so there is no busy phase.

The serial pins are treated as asynchronous. They pass through a parameterised synchronizer into the system clock domain, and the block acts on the rising edges of the serial clock that it detects there. The host must hold each serial-clock level for several system clocks.

Top module: `mw_eeprom`

## Requirements
- R1: After reset the write-enable latch is cleared, `dout` is 0 and every word reads 16'hFFFF.
- R2: With `cs` high, leading 0 bits are ignored. The first 1 sampled on a rising `sclk` edge is the start bit. It is followed by a 2-bit command code and a 6-bit address, both MSB first.
- R3: Code 10 reads a word. After the last address bit, `dout` shows a 0. The next 16 rising `sclk` edges each present one data bit, D15 first. After the 17th rising edge, `dout` returns to 0.
- R4: Code 01 is followed by 16 data bits, MSB first. When the latch is set, this stores the data in the addressed word.
- R5: Code 11, when the latch is set, sets the addressed word to 16'hFFFF.
- R6: Code 00 with address bits [5:4] = 11 sets the latch, and with [5:4] = 00 clears it. Address bits [3:0] are ignored. The latch keeps its value across chip-select cycles.
- R7: Code 00 with address bits [5:4] = 10, when the latch is set, sets every word to 16'hFFFF.
- R8: Code 00 with address bits [5:4] = 01 is followed by 16 data bits. When the latch is set, this writes the data to every word.
- R9: When the latch is clear, the write, erase, erase-all and write-all commands leave the array unchanged.
- R10: Lowering `cs` abandons a partly received frame without effect. `dout` is 0 whenever `cs` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Chip select, active high |
| sclk | input | 1 | Serial clock; bits are taken on its rising edges |
| din | input | 1 | Serial data from the host |
| dout | output | 1 | Serial data to the host |

## Verification
Every cycle, the assertions check the frame machine and the array. The frame machine must return to idle and drive `dout` low while chip select is low, must stay idle on a 0 bit seen before a start bit, and may issue each command as a single-cycle strobe. For the array, a cleared latch must leave every word unchanged, the enable and disable strobes must set and clear the latch, and erase-all must reach every word. Only the bench's scenarios can show the rest. These are the bit order of the read data with its leading zero, the correct decoding of the shared 00 code under random don't-care bits, the survival of the latch across frames, and the absence of any effect from an abandoned write.

// File: rtl/mw_eeprom_pkg.sv
package mw_eeprom_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_OPC,
      ST_ADR,
      ST_DAT,
      ST_RLD,
      ST_RD,
      ST_HOLD
   } fsm_st_e;

   typedef enum logic [2:0] {
      CM_NONE,
      CM_WRITE,
      CM_ERASE,
      CM_ERAL,
      CM_WRAL,
      CM_WEN,
      CM_WDS
   } cmd_e;

   localparam logic [1:0] OP_EXT   = 2'b00;
   localparam logic [1:0] OP_WRITE = 2'b01;
   localparam logic [1:0] OP_READ  = 2'b10;
   localparam logic [1:0] OP_ERASE = 2'b11;

   localparam logic [1:0] EX_WDS  = 2'b00;
   localparam logic [1:0] EX_WRAL = 2'b01;
   localparam logic [1:0] EX_ERAL = 2'b10;
   localparam logic [1:0] EX_WEN  = 2'b11;

endpackage

// File: rtl/mw_sync.sv
module mw_sync #(
   parameter int W      = 3,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 0) begin : g_bad_stages
      $error("mw_sync: STAGES must not be negative");
   end

   if (STAGES == 0) begin : g_bypass
      assign q = d;
   end else begin : g_chain
      logic [W-1:0] pipe [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
         end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
         end
      end
      assign q = pipe[STAGES-1];
   end

endmodule

// File: rtl/mw_cmd_fsm.sv
module mw_cmd_fsm
   import mw_eeprom_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_s,
   input  logic              sclk_s,
   input  logic              din_s,
   input  logic [DATA_W-1:0] rd_data,
   output logic [ADDR_W-1:0] cmd_addr,
   output logic [DATA_W-1:0] cmd_data,
   output logic              cmd_vld,
   output cmd_e              cmd,
   output logic              dout
);

   localparam int CW = $clog2(DATA_W + 1);

   fsm_st_e           st;
   logic              sclk_q;
   logic              rise;
   logic [CW-1:0]     cnt;
   logic [1:0]        op_q;
   logic [ADDR_W-1:0] addr_q;
   logic [ADDR_W-1:0] addr_n;
   logic [1:0]        ext;
   logic [DATA_W-1:0] data_q;
   logic [DATA_W:0]   rd_sr;

   assign rise   = sclk_s & ~sclk_q;
   assign addr_n = {addr_q[ADDR_W-2:0], din_s};
   assign ext    = addr_n[ADDR_W-1 -: 2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_q <= 1'b0;
      else        sclk_q <= sclk_s;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         cnt     <= '0;
         op_q    <= '0;
         addr_q  <= '0;
         data_q  <= '0;
         rd_sr   <= '0;
         cmd_vld <= 1'b0;
         cmd     <= CM_NONE;
      end else begin
         cmd_vld <= 1'b0;
         if (!cs_s) begin
            st    <= ST_IDLE;
            cnt   <= '0;
            rd_sr <= '0;
         end else begin
            case (st)
               ST_IDLE: begin
                  if (rise && din_s) begin
                     st  <= ST_OPC;
                     cnt <= '0;
                  end
               end
               ST_OPC: begin
                  if (rise) begin
                     op_q <= {op_q[0], din_s};
                     if (cnt == CW'(1)) begin
                        st  <= ST_ADR;
                        cnt <= '0;
                     end else begin
                        cnt <= cnt + 1'b1;
                     end
                  end
               end
               ST_ADR: begin
                  if (rise) begin
                     addr_q <= addr_n;
                     if (cnt == CW'(ADDR_W - 1)) begin
                        cnt <= '0;
                        case (op_q)
                           OP_READ:  st <= ST_RLD;
                           OP_WRITE: st <= ST_DAT;
                           OP_ERASE: begin
                              cmd     <= CM_ERASE;
                              cmd_vld <= 1'b1;
                              st      <= ST_HOLD;
                           end
                           default: begin
                              case (ext)
                                 EX_WRAL: st <= ST_DAT;
                                 EX_ERAL: begin
                                    cmd     <= CM_ERAL;
                                    cmd_vld <= 1'b1;
                                    st      <= ST_HOLD;
                                 end
                                 EX_WEN: begin
                                    cmd     <= CM_WEN;
                                    cmd_vld <= 1'b1;
                                    st      <= ST_HOLD;
                                 end
                                 default: begin
                                    cmd     <= CM_WDS;
                                    cmd_vld <= 1'b1;
                                    st      <= ST_HOLD;
                                 end
                              endcase
                           end
                        endcase
                     end else begin
                        cnt <= cnt + 1'b1;
                     end
                  end
               end
               ST_DAT: begin
                  if (rise) begin
                     data_q <= {data_q[DATA_W-2:0], din_s};
                     if (cnt == CW'(DATA_W - 1)) begin
                        cmd     <= (op_q == OP_WRITE) ? CM_WRITE : CM_WRAL;
                        cmd_vld <= 1'b1;
                        st      <= ST_HOLD;
                     end else begin
                        cnt <= cnt + 1'b1;
                     end
                  end
               end
               ST_RLD: begin
                  rd_sr <= {1'b0, rd_data};
                  cnt   <= '0;
                  st    <= ST_RD;
               end
               ST_RD: begin
                  if (rise) begin
                     rd_sr <= {rd_sr[DATA_W-1:0], 1'b0};
                     if (cnt == CW'(DATA_W)) st <= ST_HOLD;
                     else                    cnt <= cnt + 1'b1;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign cmd_addr = addr_q;
   assign cmd_data = data_q;
   assign dout     = rd_sr[DATA_W];

   // R10: a low chip select returns the frame machine to idle
   p_abort_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_s |=> st == ST_IDLE);

   // R10: no data driven while deselected
   p_dout_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_s |=> !dout);

   // R2: a zero bit before the start bit keeps the machine waiting
   p_lead_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && cs_s && rise && !din_s) |=> st == ST_IDLE);

   // R2: each frame issues a command as a single-cycle strobe
   p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_vld |=> !cmd_vld);

endmodule

// File: rtl/mw_array.sv
module mw_array
   import mw_eeprom_pkg::*;
#(
   parameter int              ADDR_W    = 6,
   parameter int              DATA_W    = 16,
   parameter logic [DATA_W-1:0] ERASE_VAL = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_vld,
   input  cmd_e              cmd,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [DATA_W-1:0] cmd_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);

   localparam int WORDS = 1 << ADDR_W;

   logic              wen_q;
   logic [DATA_W-1:0] word_q [WORDS];
   logic              prog;
   logic              single;
   logic              bulk;
   logic [DATA_W-1:0] new_val;

   assign prog    = cmd_vld && wen_q;
   assign single  = (cmd == CM_WRITE) || (cmd == CM_ERASE);
   assign bulk    = (cmd == CM_ERAL) || (cmd == CM_WRAL);
   assign new_val = ((cmd == CM_WRITE) || (cmd == CM_WRAL)) ? cmd_data : ERASE_VAL;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          wen_q <= 1'b0;
      else if (cmd_vld && cmd == CM_WEN)   wen_q <= 1'b1;
      else if (cmd_vld && cmd == CM_WDS)   wen_q <= 1'b0;
   end

   for (genvar g = 0; g < WORDS; g++) begin : g_word
      logic hit;
      assign hit = prog && ((single && cmd_addr == ADDR_W'(g)) || bulk);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   word_q[g] <= ERASE_VAL;
         else if (hit) word_q[g] <= new_val;
      end

      // R9: a cleared latch freezes every word
      p_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
         !wen_q |=> $stable(word_q[g]));

      // R7: erase-all reaches every word
      p_eral_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (cmd_vld && wen_q && cmd == CM_ERAL) |=> word_q[g] == ERASE_VAL);
   end

   assign rd_data = word_q[rd_addr];

   // R6: enable strobe sets the latch
   p_wen_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_vld && cmd == CM_WEN) |=> wen_q);

   // R6: disable strobe clears the latch
   p_wen_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_vld && cmd == CM_WDS) |=> !wen_q);

endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom
   import mw_eeprom_pkg::*;
#(
   parameter int                ADDR_W      = 6,
   parameter int                DATA_W      = 16,
   parameter int                SYNC_STAGES = 2,
   parameter logic [DATA_W-1:0] ERASE_VAL   = '1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs,
   input  logic sclk,
   input  logic din,
   output logic dout
);

   if (ADDR_W < 2 || ADDR_W > 10) begin : g_bad_addr
      $error("mw_eeprom: ADDR_W must lie in 2..10");
   end
   if (DATA_W < 2) begin : g_bad_data
      $error("mw_eeprom: DATA_W must be at least 2");
   end

   logic [2:0]        pins_s;
   logic              cs_s;
   logic              sclk_s;
   logic              din_s;
   logic [DATA_W-1:0] rd_data;
   logic [ADDR_W-1:0] cmd_addr;
   logic [DATA_W-1:0] cmd_data;
   logic              cmd_vld;
   cmd_e              cmd;

   mw_sync #(.W(3), .STAGES(SYNC_STAGES)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({cs, sclk, din}),
      .q     (pins_s)
   );

   assign {cs_s, sclk_s, din_s} = pins_s;

   mw_cmd_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .cs_s     (cs_s),
      .sclk_s   (sclk_s),
      .din_s    (din_s),
      .rd_data  (rd_data),
      .cmd_addr (cmd_addr),
      .cmd_data (cmd_data),
      .cmd_vld  (cmd_vld),
      .cmd      (cmd),
      .dout     (dout)
   );

   mw_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ERASE_VAL(ERASE_VAL)) i_array (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd_vld  (cmd_vld),
      .cmd      (cmd),
      .cmd_addr (cmd_addr),
      .cmd_data (cmd_data),
      .rd_addr  (cmd_addr),
      .rd_data  (rd_data)
   );

endmodule

// File: tb/test_mw_eeprom.sv
`timescale 1ns/1ps
module test_mw_eeprom;

   localparam int H = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs = 1'b0;
   logic sclk = 1'b0;
   logic din = 1'b0;
   logic dout;

   logic [15:0] ref_mem [64];
   logic        ref_wen;
   int          n_vec = 0;
   int          n_bad = 0;

   always #2.5 clk = ~clk;

   mw_eeprom i_mw_eeprom (
      .clk (clk), .rst_n (rst_n), .cs (cs), .sclk (sclk), .din (din), .dout (dout)
   );

   function automatic logic [15:0] exp_word(input int a);
      return ref_mem[a];
   endfunction

   function automatic logic needs_data(input logic [1:0] op, input logic [5:0] a);
      return (op == 2'b01) || (op == 2'b00 && a[5:4] == 2'b01);
   endfunction

   task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
      n_vec++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic wait_h();
      repeat (H) @(negedge clk);
   endtask

   task automatic sbit(input logic b);
      din = b; sclk = 1'b0; wait_h();
      sclk = 1'b1; wait_h();
   endtask

   task automatic cs_on();
      sclk = 1'b0; din = 1'b0; cs = 1'b1; wait_h();
   endtask

   task automatic cs_off();
      sclk = 1'b0; din = 1'b0; wait_h();
      cs = 1'b0; wait_h();
   endtask

   task automatic send_hdr(input logic [1:0] op, input logic [5:0] a);
      sbit(1'b1);
      sbit(op[1]); sbit(op[0]);
      for (int i = 5; i >= 0; i--) sbit(a[i]);
   endtask

   task automatic model(input logic [1:0] op, input logic [5:0] a, input logic [15:0] d);
      case (op)
         2'b01: if (ref_wen) ref_mem[a] = d;
         2'b11: if (ref_wen) ref_mem[a] = 16'hFFFF;
         2'b00: case (a[5:4])
            2'b11: ref_wen = 1'b1;
            2'b00: ref_wen = 1'b0;
            2'b10: if (ref_wen) for (int i = 0; i < 64; i++) ref_mem[i] = 16'hFFFF;
            default: if (ref_wen) for (int i = 0; i < 64; i++) ref_mem[i] = d;
         endcase
         default: ;
      endcase
   endtask

   task automatic do_cmd(input logic [1:0] op, input logic [5:0] a, input logic [15:0] d);
      cs_on();
      send_hdr(op, a);
      if (needs_data(op, a)) for (int i = 15; i >= 0; i--) sbit(d[i]);
      cs_off();
      model(op, a, d);
   endtask

   task automatic rd_chk(input logic [5:0] a, input int lead, input string req);
      logic [15:0] w;
      w = '0;
      cs_on();
      for (int i = 0; i < lead; i++) sbit(1'b0);
      send_hdr(2'b10, a);
      for (int i = 0; i <= 16; i++) begin
         sclk = 1'b0; wait_h();
         if (i == 0) chk("R3 dummy zero", {15'd0, dout}, 16'd0);
         else        w = {w[14:0], dout};
         sclk = 1'b1; wait_h();
      end
      sclk = 1'b0; wait_h();
      chk("R3 trailing zero", {15'd0, dout}, 16'd0);
      cs_off();
      chk(req, w, exp_word(int'(a)));
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] r;
      for (int i = 0; i < 64; i++) ref_mem[i] = 16'hFFFF;
      ref_wen = 1'b0;
      r = $urandom(32'd20240);
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      wait_h();

      // R1: reset state
      chk("R1 dout at reset", {15'd0, dout}, 16'd0);
      rd_chk(6'd0, 0, "R1 word 0 erased");
      rd_chk(6'd63, 0, "R1 word 63 erased");

      // R9: locked latch blocks programming
      do_cmd(2'b01, 6'd5, 16'h1234);
      rd_chk(6'd5, 0, "R9 write while locked");
      do_cmd(2'b00, 6'b01_0000, 16'h0000);
      rd_chk(6'd9, 0, "R9 write-all while locked");

      // R6: enable with random don't-care bits
      do_cmd(2'b00, {2'b11, 4'($urandom)}, 16'h0);
      do_cmd(2'b01, 6'd5, 16'hA5C3);
      rd_chk(6'd5, 0, "R4 write after enable");
      do_cmd(2'b01, 6'd63, 16'h8001);
      rd_chk(6'd63, 0, "R4 top address");

      // R2: leading zeros before start bit
      rd_chk(6'd5, 3, "R2 leading zeros");

      // R5: erase single word
      do_cmd(2'b11, 6'd5, 16'h0);
      rd_chk(6'd5, 0, "R5 erase word");
      rd_chk(6'd63, 0, "R5 neighbour kept");

      // R8 / R7
      do_cmd(2'b00, {2'b01, 4'($urandom)}, 16'h3C5A);
      rd_chk(6'd0, 0, "R8 write-all word 0");
      rd_chk(6'd40, 0, "R8 write-all word 40");
      do_cmd(2'b00, {2'b10, 4'($urandom)}, 16'h0);
      rd_chk(6'd17, 0, "R7 erase-all word 17");

      // R6: disable then latch persists across frames
      do_cmd(2'b00, {2'b00, 4'($urandom)}, 16'h0);
      do_cmd(2'b01, 6'd7, 16'h0F0F);
      rd_chk(6'd7, 0, "R6 write after disable");
      do_cmd(2'b00, 6'b11_1010, 16'h0);
      rd_chk(6'd2, 0, "R6 idle frame");
      do_cmd(2'b01, 6'd7, 16'h0F0F);
      rd_chk(6'd7, 0, "R6 latch kept across frames");

      // R10: abort mid-data
      cs_on();
      send_hdr(2'b01, 6'd7);
      for (int i = 0; i < 7; i++) sbit(1'b0);
      cs_off();
      chk("R10 dout low after abort", {15'd0, dout}, 16'd0);
      rd_chk(6'd7, 0, "R10 aborted write");

      // random mix
      for (int n = 0; n < 110; n++) begin
         logic [5:0]  a;
         logic [15:0] d;
         int          k;
         a = 6'($urandom);
         d = 16'($urandom);
         k = int'($urandom_range(0, 9));
         case (k)
            0, 1, 2: rd_chk(a, int'($urandom_range(0, 2)), "R3 random read");
            3, 4: begin do_cmd(2'b01, a, d); rd_chk(a, 0, "R4 random write"); end
            5: begin do_cmd(2'b11, a, d); rd_chk(a, 0, "R5 random erase"); end
            6: do_cmd(2'b00, {2'b11, a[3:0]}, d);
            7: if ($urandom_range(0, 2) == 0) do_cmd(2'b00, {2'b00, a[3:0]}, d);
            8: begin
               if ($urandom_range(0, 3) == 0) do_cmd(2'b00, {2'b10, a[3:0]}, d);
               else                           do_cmd(2'b01, a, d);
               rd_chk(a, 0, "R7 random erase-all or write");
            end
            default: begin
               if ($urandom_range(0, 3) == 0) do_cmd(2'b00, {2'b01, a[3:0]}, d);
               rd_chk(6'($urandom), 0, "R8 random write-all or read");
            end
         endcase
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule